// File: doc/BRIEF.md
# Receive FIFO Time-out Detector

This block watches a receive data FIFO and a frame status FIFO and raises a time-out whenever data has been sitting in either of them for too long without fresh arrivals and without the host reading. It lets a host or DMA engine collect a short tail of data that never reaches the service threshold. The limits depend on the operating mode. In the wired / low-speed infrared mode, the limit is a number of character times. In the high-speed infrared mode, it is a short and a long microsecond window. In the consumer remote-control mode, it is the short window together with a receiver-idle condition.

Several saturating timers run side by side. They count since the last receive push, since the last data pop, since the last status pop, in character times, and since the receiver went idle. Mode-specific combinations of these timers set sticky flags, and a flag stays set until the FIFO that caused it is read. The character tick and the microsecond tick come from outside. The character tick is already scaled for the current word length and baud rate.

Top module: `rx_timeout_detector`

## Requirements
- R1: With `mode` = 1 (high-speed IR), `rx_timeout` sets when `rx_level` is non-zero and at least SHORT_US microsecond ticks have occurred both since the last `rx_push` and since the last `rx_pop`.
- R2: `st_timeout` sets only with `mode` = 1. It sets when `st_level` is non-zero and at least LONG_US microsecond ticks have occurred both since the last `rx_push` and since the last `st_pop`. In any other mode it never sets.
- R3: With `mode` = 0 (wired or low-speed IR), `rx_timeout` sets when `rx_level` is non-zero and at least CHAR_LIMIT character ticks have occurred both since the last `rx_push` and since the last `rx_pop`. Microsecond ticks have no effect in this mode.
- R4: With `mode` = 2 (remote control), `rx_timeout` never sets while `rx_active` is high. It sets only when `rx_level` is non-zero and all of the following have seen at least SHORT_US microsecond ticks: the time since the last `rx_push`, the time since the last `rx_pop`, and the time with `rx_active` low. Mode code 3 produces no receive time-out.
- R5: Once set, `rx_timeout` stays high until `rx_pop`. Once set, `st_timeout` stays high until `st_pop`. Neither pop clears the other flag.
- R6: When `rx_timeout` sets while `rx_level` < `rx_thresh`, `rx_below_thr` sets with it. It clears on `rx_pop`. It stays low if the level is at or above the threshold when the time-out sets.
- R7: With `rx_level` = 0, `rx_timeout` never sets, however long the timers run.
- R8: An `rx_pop` in the cycle in which the set condition first holds wins. `rx_timeout` stays low and the counting restarts.
- R9: Each timer saturates at its limit rather than wrapping. Any number of extra ticks leaves an expired condition expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 wired/low-speed IR, 1 high-speed IR, 2 remote control, 3 reserved |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_thresh | input | LVL_W | Receive FIFO service threshold |
| st_level | input | ST_W | Status FIFO occupancy |
| rx_push | input | 1 | Receiver loads a byte into the receive FIFO |
| rx_pop | input | 1 | Host or DMA reads a byte from the receive FIFO |
| st_pop | input | 1 | Host reads a status FIFO entry |
| rx_active | input | 1 | Remote-control receiver is active |
| char_tick | input | 1 | One-cycle pulse per character time |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| rx_timeout | output | 1 | Sticky receive FIFO time-out |
| st_timeout | output | 1 | Sticky status FIFO time-out |
| rx_below_thr | output | 1 | Time-out occurred with level below threshold |

## Verification
The set condition of the receive time-out and its clearing read can fall in the same cycle. The bench provokes this by driving `rx_pop` in the cycle right after the tick that brings the timers to their limits, which is exactly the cycle in which the set condition is first sampled. The bench then requires the flag to stay low, and to set again only after a further full window, because the pop also restarted the since-read count.

// File: rtl/rxto_pkg.sv
// Shared mode encoding for the receive time-out detector.
package rxto_pkg;
    typedef enum logic [1:0] {
        MODE_WIRED  = 2'd0,
        MODE_HSIR   = 2'd1,
        MODE_REMOTE = 2'd2,
        MODE_RSVD   = 2'd3
    } rx_mode_e;
endpackage

// File: rtl/sat_timer.sv
// Saturating event counter.
// Counts tick pulses up to LIMIT and holds there. A restart forces zero
// and takes precedence over a tick in the same cycle.
// Assumes tick and restart are single-cycle qualified strobes.
module sat_timer #(
    parameter int LIMIT = 64,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    // Count ticks, restart to zero, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (tick && cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM) else $error("count above limit"); // R9
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LIM && !restart) |=> cnt == LIM) else $error("saturated count moved"); // R9
endmodule

// File: rtl/to_flag.sv
// Sticky flag: set by a condition, cleared by a read strobe.
// Clear has priority over set in the same cycle.
module to_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag until the clearing read arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
    end
endmodule

// File: rtl/rx_timeout_detector.sv
// Receive and status FIFO time-out detector.
// Runs saturating timers since the last push, the last data pop, the last
// status pop, in character ticks, and over receiver-idle time, then combines
// them by mode into sticky time-out flags.
// Assumes SHORT_US <= LONG_US and that ticks come from free-running dividers.
module rx_timeout_detector
    import rxto_pkg::*;
#(
    parameter int LVL_W      = 6,
    parameter int ST_W       = 4,
    parameter int SHORT_US   = 64,
    parameter int LONG_US    = 1000,
    parameter int CHAR_LIMIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_thresh,
    input  logic [ST_W-1:0]  st_level,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             st_pop,
    input  logic             rx_active,
    input  logic             char_tick,
    input  logic             us_tick,
    output logic             rx_timeout,
    output logic             st_timeout,
    output logic             rx_below_thr
);
    localparam int LW = $clog2(LONG_US + 1);
    localparam int SW = $clog2(SHORT_US + 1);
    localparam int CW = $clog2(CHAR_LIMIT + 1);
    localparam logic [LW-1:0] LONG_L  = LW'(LONG_US);
    localparam logic [LW-1:0] SHORT_L = LW'(SHORT_US);
    localparam logic [SW-1:0] SHORT_S = SW'(SHORT_US);
    localparam logic [CW-1:0] CHAR_C  = CW'(CHAR_LIMIT);

    rx_mode_e mode_e;
    assign mode_e = rx_mode_e'(mode);

    logic [LW-1:0] us_since_push;
    logic [SW-1:0] us_since_pop;
    logic [LW-1:0] us_since_stpop;
    logic [SW-1:0] us_idle;
    logic [CW-1:0] ch_since_push;
    logic [CW-1:0] ch_since_pop;

    sat_timer #(.LIMIT(LONG_US)) i_push_us (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .restart(rx_push), .cnt(us_since_push));
    sat_timer #(.LIMIT(SHORT_US)) i_pop_us (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .restart(rx_pop), .cnt(us_since_pop));
    sat_timer #(.LIMIT(LONG_US)) i_stpop_us (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .restart(st_pop), .cnt(us_since_stpop));
    sat_timer #(.LIMIT(SHORT_US)) i_idle_us (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .restart(rx_active), .cnt(us_idle));
    sat_timer #(.LIMIT(CHAR_LIMIT)) i_push_ch (
        .clk(clk), .rst_n(rst_n), .tick(char_tick), .restart(rx_push), .cnt(ch_since_push));
    sat_timer #(.LIMIT(CHAR_LIMIT)) i_pop_ch (
        .clk(clk), .rst_n(rst_n), .tick(char_tick), .restart(rx_pop), .cnt(ch_since_pop));

    logic rx_has_data, st_has_data;
    logic push_short_ok, pop_short_ok, idle_ok, char_ok, long_ok;
    logic rx_set, st_set, below_set;

    // Per-window expiry terms derived from the timer counts.
    always_comb begin
        rx_has_data   = (rx_level != '0);
        st_has_data   = (st_level != '0);
        push_short_ok = (us_since_push >= SHORT_L);
        pop_short_ok  = (us_since_pop == SHORT_S);
        idle_ok       = (us_idle == SHORT_S) && !rx_active;
        char_ok       = (ch_since_push == CHAR_C) && (ch_since_pop == CHAR_C);
        long_ok       = (us_since_push == LONG_L) && (us_since_stpop == LONG_L);
    end

    // Select the receive set condition by operating mode.
    always_comb begin
        case (mode_e)
            MODE_WIRED:  rx_set = rx_has_data && char_ok;
            MODE_HSIR:   rx_set = rx_has_data && push_short_ok && pop_short_ok;
            MODE_REMOTE: rx_set = rx_has_data && push_short_ok && pop_short_ok && idle_ok;
            default:     rx_set = 1'b0;
        endcase
        st_set    = (mode_e == MODE_HSIR) && st_has_data && long_ok;
        below_set = rx_set && !rx_timeout && (rx_level < rx_thresh);
    end

    to_flag i_rx_flag (
        .clk(clk), .rst_n(rst_n), .set(rx_set), .clr(rx_pop), .q(rx_timeout));
    to_flag i_st_flag (
        .clk(clk), .rst_n(rst_n), .set(st_set), .clr(st_pop), .q(st_timeout));
    to_flag i_below_flag (
        .clk(clk), .rst_n(rst_n), .set(below_set), .clr(rx_pop), .q(rx_below_thr));

    AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_timeout && !rx_pop) |=> rx_timeout) else $error("rx flag dropped"); // R5
    AST_ST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_timeout && !st_pop) |=> st_timeout) else $error("st flag dropped"); // R5
    AST_POP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> !rx_timeout) else $error("rx flag survived pop"); // R8
    AST_ST_HSIR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_timeout) |-> $past(mode) == MODE_HSIR) else $error("st flag outside high-speed mode"); // R2
    AST_REMOTE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_timeout) |-> !($past(mode) == MODE_REMOTE && $past(rx_active)))
        else $error("remote time-out while active"); // R4
    AST_NO_EMPTY_TO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_timeout) |-> $past(rx_level) != '0) else $error("time-out on empty FIFO"); // R7
    AST_BELOW_WITH_TO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_below_thr |-> rx_timeout) else $error("below flag without time-out"); // R6
endmodule

// File: tb/test_rx_timeout_detector.sv
`timescale 1ns/1ps
module test_rx_timeout_detector;
    localparam int LVL_W = 5, ST_W = 4, SHORT = 4, LONG = 10, CHARL = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] mode = 2'd1;
    logic [LVL_W-1:0] rx_level = '0, rx_thresh = 5'd4;
    logic [ST_W-1:0] st_level = '0;
    logic rx_push = 0, rx_pop = 0, st_pop = 0, rx_active = 0, char_tick = 0, us_tick = 0;
    logic rx_timeout, st_timeout, rx_below_thr;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rx_timeout_detector #(.LVL_W(LVL_W), .ST_W(ST_W), .SHORT_US(SHORT),
                          .LONG_US(LONG), .CHAR_LIMIT(CHARL)) i_rx_timeout_detector (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rx_level(rx_level), .rx_thresh(rx_thresh),
        .st_level(st_level), .rx_push(rx_push), .rx_pop(rx_pop), .st_pop(st_pop),
        .rx_active(rx_active), .char_tick(char_tick), .us_tick(us_tick),
        .rx_timeout(rx_timeout), .st_timeout(st_timeout), .rx_below_thr(rx_below_thr));

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_us(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1; cyc(1); us_tick = 0; cyc(1);
        end
    endtask

    task automatic tick_ch(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1; cyc(1); char_tick = 0; cyc(1);
        end
    endtask

    // restart every timer and clear the flags
    task automatic restart_all();
        rx_push = 1; rx_pop = 1; st_pop = 1; cyc(1);
        rx_push = 0; rx_pop = 0; st_pop = 0; cyc(1);
    endtask

    initial begin
        cyc(3);
        rst_n = 1; cyc(1);
        check("R5 reset rx", rx_timeout, 0);
        check("R5 reset st", st_timeout, 0);
        check("R6 reset below", rx_below_thr, 0);

        // R1 sweep in high-speed mode
        mode = 2'd1; rx_level = 5'd1;
        for (int k = 0; k <= SHORT + 2; k++) begin
            restart_all(); tick_us(k); cyc(2);
            check("R1 hsir sweep", rx_timeout, k >= SHORT);
        end
        // R1 push restarts the since-load window
        restart_all(); tick_us(SHORT - 1); rx_push = 1; cyc(1); rx_push = 0; cyc(1);
        tick_us(SHORT - 1); cyc(2);
        check("R1 push restart", rx_timeout, 0);
        tick_us(1); cyc(2);
        check("R1 push restart fire", rx_timeout, 1);

        // R5 sticky; st_pop does not clear rx flag
        tick_us(3); st_pop = 1; cyc(1); st_pop = 0; cyc(2);
        check("R5 rx sticky", rx_timeout, 1);
        rx_pop = 1; cyc(1); rx_pop = 0; cyc(1);
        check("R5 rx cleared by pop", rx_timeout, 0);

        // R6 below-threshold indication
        rx_level = 5'd1; restart_all(); tick_us(SHORT); cyc(2);
        check("R6 below set", rx_below_thr, 1);
        rx_pop = 1; cyc(1); rx_pop = 0; cyc(1);
        check("R6 below cleared", rx_below_thr, 0);
        rx_level = 5'd5; restart_all(); tick_us(SHORT); cyc(2);
        check("R6 at threshold to", rx_timeout, 1);
        check("R6 at threshold below", rx_below_thr, 0);

        // R7 empty FIFO never times out
        rx_level = 5'd0; restart_all(); tick_us(LONG + 3); cyc(2);
        check("R7 empty", rx_timeout, 0);

        // R9 saturation: 17 ticks would wrap any counter narrow enough to hold the limit
        rx_level = 5'd0; restart_all(); tick_us(17); rx_level = 5'd1; cyc(3);
        check("R9 saturation", rx_timeout, 1);

        // R2 status sweep in high-speed mode
        rx_level = 5'd1; st_level = 4'd1;
        for (int k = LONG - 2; k <= LONG + 1; k++) begin
            restart_all(); tick_us(k); cyc(2);
            check("R2 st sweep", st_timeout, k >= LONG);
        end
        rx_pop = 1; cyc(1); rx_pop = 0; cyc(2);
        check("R5 st kept after rx pop", st_timeout, 1);
        st_pop = 1; cyc(1); st_pop = 0; cyc(1);
        check("R5 st cleared", st_timeout, 0);
        st_level = 4'd0; restart_all(); tick_us(LONG + 2); cyc(2);
        check("R2 st empty", st_timeout, 0);
        st_level = 4'd1;

        // R3 wired mode: character ticks
        mode = 2'd0;
        restart_all(); tick_us(LONG + 2); cyc(2);
        check("R3 us ignored", rx_timeout, 0);
        check("R2 st off in wired", st_timeout, 0);
        for (int k = 0; k <= CHARL + 1; k++) begin
            restart_all(); tick_ch(k); cyc(2);
            check("R3 char sweep", rx_timeout, k >= CHARL);
        end

        // R4 remote mode
        mode = 2'd2;
        for (int k = 0; k <= SHORT + 1; k++) begin
            rx_active = 1; restart_all(); tick_us(SHORT + 2); cyc(2);
            check("R4 active suppress", rx_timeout, 0);
            rx_active = 0; tick_us(k); cyc(2);
            check("R4 idle sweep", rx_timeout, k >= SHORT);
        end
        check("R2 st off in remote", st_timeout, 0);
        rx_active = 0;
        mode = 2'd3; restart_all(); tick_us(LONG + 2); tick_ch(CHARL + 1); cyc(2);
        check("R4 reserved mode", rx_timeout, 0);

        // R8 pop in the cycle the set condition first holds
        mode = 2'd1; rx_level = 5'd1;
        restart_all(); tick_us(SHORT - 1);
        us_tick = 1; cyc(1); us_tick = 0; rx_pop = 1; cyc(1); rx_pop = 0; cyc(2);
        check("R8 pop wins", rx_timeout, 0);
        tick_us(SHORT - 1); cyc(2);
        check("R8 restarted window", rx_timeout, 0);
        tick_us(1); cyc(2);
        check("R8 later fire", rx_timeout, 1);

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule